// File: doc/BRIEF.md
# Configuration Change Guard

This block keeps a small group of sensitive I/O registers from being changed by a stray write. The CPU's I/O write port (address, data and write strobe) and its instruction-retire strobe are fed into the guard. A write of the unlock key to the guard's own register opens a short window. While the window is open, the guard raises a write-enable for the protected registers and holds off interrupt acceptance. Outside the window, a write to a protected address produces no enable, so the write is dropped.

The window is measured in retired instructions, not clock cycles, so an instruction that takes several cycles counts as one. Changing a protected setting takes two steps: software writes the key, then writes the target register before the window has run out. The guard's own register reads back bit 0 as the window state and zero everywhere else.

Top module: `cfg_guard`

## Requirements
- R1: After reset the window is closed, `irq_hold` and `prot_we` are low, and a read of address 0x3C returns 0x00.
- R2: A write of 0xD8 to address 0x3C (the key write) opens the window from the next clock cycle.
- R3: Once opened, the window stays open until the fourth retire strobe that follows the key-write cycle. A protected write in the same cycle as that fourth strobe still succeeds, and the window is closed from the next cycle. A retire strobe in the key-write cycle itself is not counted.
- R4: `irq_hold` is high in exactly the cycles in which the window is open.
- R5: `io_rdata` is {7'b0, window open} when `io_addr` is 0x3C, and 0x00 for every other address.
- R6: The protected addresses are 0x37 (clock source select), 0x36 (clock prescale) and 0x31 (watchdog control). `prot_we` is high only in a cycle with `io_we` high, `io_addr` on one of these addresses and the window open. It never rises for any other address.
- R7: A write of any value other than 0xD8 to 0x3C neither opens the window nor closes or shortens an open one.
- R8: A key write while the window is open restarts the count at four retire strobes.
- R9: Any number of protected writes may be made in one window, and they do not close it early.
- R10: Cycles with the retire strobe low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 6 | I/O address of the current access |
| io_wdata | input | 8 | I/O write data |
| io_we | input | 1 | I/O write strobe |
| instr_retire | input | 1 | High for one cycle when an instruction completes |
| io_rdata | output | 8 | Readback of the guard register (window state in bit 0) |
| prot_we | output | 1 | Write-enable for the protected register group |
| irq_hold | output | 1 | Holds off interrupt acceptance while the window is open |

## Verification
A wrong count value shows up in the first cycle in which a protected write lands outside the legal span. If the count is one too long, a write one instruction after the fourth strobe still raises `prot_we`. If it is one too short, the write made in the cycle of the fourth strobe is lost, and `irq_hold` and bit 0 of the readback fall one instruction early. A failed reload or a stale count is visible at the ports no later than the cycle after the fourth retire strobe, because the window edge is then misplaced on all three outputs together. The stub registers in the bench turn a wrong enable into a wrong stored value, which stays visible until that register is written again.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
   localparam int unsigned IO_AW = 6;
   localparam int unsigned IO_DW = 8;
   localparam logic [IO_AW-1:0] KEY_ADDR_DEF  = 6'h3C;
   localparam logic [IO_DW-1:0] KEY_VALUE_DEF = 8'hD8;
   localparam int unsigned      WINDOW_DEF    = 4;
   localparam int unsigned      NUM_PROT_DEF  = 3;
   // protected addresses, entry 0 in the low bits
   localparam logic [NUM_PROT_DEF*IO_AW-1:0] PROT_ADDRS_DEF = {6'h31, 6'h36, 6'h37};
endpackage

// File: rtl/cfg_guard_key.sv
module cfg_guard_key #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 8,
   parameter logic [AW-1:0] KEY_ADDR  = '0,
   parameter logic [DW-1:0] KEY_VALUE = '0
) (
   input  logic [AW-1:0] io_addr,
   input  logic [DW-1:0] io_wdata,
   input  logic          io_we,
   output logic          key_sel,
   output logic          sig_hit
);
   if (KEY_VALUE == '0) begin : g_bad_key
      $error("cfg_guard_key: an all-zero key equals the reset value");
   end

   assign key_sel = (io_addr == KEY_ADDR);
   assign sig_hit = io_we && key_sel && (io_wdata == KEY_VALUE);
endmodule

// File: rtl/cfg_guard_window.sv
module cfg_guard_window #(
   parameter int unsigned WINDOW_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_hit,
   input  logic instr_retire,
   output logic win_open
);
   localparam int unsigned CW = $clog2(WINDOW_LEN + 1);
   localparam logic [CW-1:0] LOAD = CW'(WINDOW_LEN);

   if (WINDOW_LEN < 1) begin : g_bad_len
      $error("cfg_guard_window: WINDOW_LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sig_hit) begin
         cnt_q <= LOAD;
      end else if (instr_retire && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign win_open = (cnt_q != '0);

   assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sig_hit |=> win_open);
   assert_reload_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sig_hit |=> (cnt_q == LOAD));
   assert_hold_without_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sig_hit && !instr_retire) |=> $stable(cnt_q));
   assert_close_on_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(win_open) |-> $past(instr_retire));
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);
endmodule

// File: rtl/cfg_guard_gate.sv
module cfg_guard_gate #(
   parameter int unsigned AW = 6,
   parameter int unsigned NUM_PROT = 3,
   parameter logic [AW-1:0] KEY_ADDR = '0,
   parameter logic [NUM_PROT*AW-1:0] PROT_ADDRS = '0
) (
   input  logic [AW-1:0] io_addr,
   input  logic          io_we,
   input  logic          win_open,
   output logic          prot_we
);
   if (NUM_PROT < 1) begin : g_bad_num
      $error("cfg_guard_gate: NUM_PROT must be at least 1");
   end

   logic [NUM_PROT-1:0] hit;

   for (genvar i = 0; i < NUM_PROT; i++) begin : g_match
      if (PROT_ADDRS[i*AW +: AW] == KEY_ADDR) begin : g_clash
         $error("cfg_guard_gate: protected address equals key address");
      end
      assign hit[i] = (io_addr == PROT_ADDRS[i*AW +: AW]);
   end

   assign prot_we = io_we && win_open && (|hit);
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
   import cfg_guard_pkg::*;
#(
   parameter int unsigned AW = IO_AW,
   parameter int unsigned DW = IO_DW,
   parameter logic [AW-1:0] KEY_ADDR  = KEY_ADDR_DEF,
   parameter logic [DW-1:0] KEY_VALUE = KEY_VALUE_DEF,
   parameter int unsigned WINDOW_LEN  = WINDOW_DEF,
   parameter int unsigned NUM_PROT    = NUM_PROT_DEF,
   parameter logic [NUM_PROT*AW-1:0] PROT_ADDRS = PROT_ADDRS_DEF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] io_addr,
   input  logic [DW-1:0] io_wdata,
   input  logic          io_we,
   input  logic          instr_retire,
   output logic [DW-1:0] io_rdata,
   output logic          prot_we,
   output logic          irq_hold
);
   if (DW < 2) begin : g_bad_dw
      $error("cfg_guard: DW must be at least 2");
   end

   logic key_sel;
   logic sig_hit;
   logic win_open;

   cfg_guard_key #(.AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY_VALUE(KEY_VALUE)) u_key (
      .io_addr (io_addr),
      .io_wdata(io_wdata),
      .io_we   (io_we),
      .key_sel (key_sel),
      .sig_hit (sig_hit)
   );

   cfg_guard_window #(.WINDOW_LEN(WINDOW_LEN)) u_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .sig_hit     (sig_hit),
      .instr_retire(instr_retire),
      .win_open    (win_open)
   );

   cfg_guard_gate #(.AW(AW), .NUM_PROT(NUM_PROT), .KEY_ADDR(KEY_ADDR),
                    .PROT_ADDRS(PROT_ADDRS)) u_gate (
      .io_addr (io_addr),
      .io_we   (io_we),
      .win_open(win_open),
      .prot_we (prot_we)
   );

   assign irq_hold = win_open;
   assign io_rdata = key_sel ? {{(DW-1){1'b0}}, win_open} : '0;

   assert_enable_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prot_we |-> irq_hold);
   assert_readback_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      key_sel |-> (io_rdata[0] == irq_hold));
endmodule

// File: tb/test_cfg_guard.sv
module test_cfg_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] io_addr = '0;
   logic [7:0] io_wdata = '0;
   logic       io_we = 1'b0;
   logic       instr_retire = 1'b0;
   logic [7:0] io_rdata;
   logic       prot_we;
   logic       irq_hold;

   int checks = 0;
   int fails = 0;
   int ref_cnt = 0;
   logic [7:0] stub_ps = 8'h00, exp_ps = 8'h00;
   bit done = 0;

   always #2.5 clk = ~clk;

   cfg_guard i_cfg_guard (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_we(io_we), .instr_retire(instr_retire), .io_rdata(io_rdata),
      .prot_we(prot_we), .irq_hold(irq_hold)
   );

   function automatic bit is_prot(input logic [5:0] a);
      return (a == 6'h37) || (a == 6'h36) || (a == 6'h31);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [5:0] a, input bit open);
      return (a == 6'h3C) ? {7'b0, open} : 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle: drive at negedge, check before the edge, update model after it
   task automatic step(input logic [5:0] a, input logic [7:0] d, input bit we,
                       input bit ret, input string tag);
      bit open, pwe;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_we = we; instr_retire = ret;
      #1;
      open = (ref_cnt != 0);
      pwe  = we && is_prot(a) && open;
      check($sformatf("%s R4 irq_hold", tag), {7'b0, irq_hold}, {7'b0, open});
      check($sformatf("%s R6 prot_we", tag), {7'b0, prot_we}, {7'b0, pwe});
      check($sformatf("%s R5 rdata", tag), io_rdata, exp_rd(a, open));
      @(posedge clk);
      if (pwe && a == 6'h36) exp_ps = d;
      if (we && a == 6'h3C && d == 8'hD8) ref_cnt = 4;
      else if (ret && ref_cnt != 0) ref_cnt--;
   endtask

   // protected register stub for address 0x36
   always_ff @(posedge clk) if (prot_we && io_addr == 6'h36) stub_ps <= io_wdata;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R3 watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h00C0FFEE;
      void'($urandom(seed));
      io_addr = 6'h3C;
      #7;
      check("R1 reset irq_hold", {7'b0, irq_hold}, 8'h00);
      check("R1 reset rdata", io_rdata, 8'h00);
      check("R1 reset prot_we", {7'b0, prot_we}, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      step(6'h36, 8'hA5, 1, 1, "R6 closed write dropped");
      step(6'h3C, 8'h00, 0, 0, "R1 closed after reset");
      step(6'h3C, 8'h12, 1, 1, "R7 wrong key");
      step(6'h3C, 8'h00, 0, 0, "R7 still closed");
      step(6'h3C, 8'hD8, 1, 1, "R2 key write");
      step(6'h3C, 8'h00, 0, 0, "R2 open");
      step(6'h00, 8'h00, 0, 0, "R10 no retire");
      step(6'h36, 8'h11, 1, 1, "R9 first write");
      step(6'h37, 8'h22, 1, 1, "R9 second write");
      step(6'h3C, 8'h5A, 1, 0, "R7 wrong key while open");
      step(6'h3C, 8'h00, 0, 1, "R7 still open");
      step(6'h36, 8'h33, 1, 1, "R3 write on fourth retire");
      step(6'h36, 8'h44, 1, 0, "R3 write after close");
      step(6'h3C, 8'h00, 0, 0, "R3 closed");
      check("R6 stub after window", stub_ps, exp_ps);
      check("R3 stub holds last legal", stub_ps, 8'h33);
      step(6'h3C, 8'hD8, 1, 0, "R8 key");
      step(6'h10, 8'h00, 0, 1, "R8 retire");
      step(6'h10, 8'h00, 0, 1, "R8 retire");
      step(6'h3C, 8'hD8, 1, 1, "R8 rekey");
      step(6'h10, 8'h00, 0, 1, "R8 retire");
      step(6'h10, 8'h00, 0, 1, "R8 retire");
      step(6'h10, 8'h00, 0, 1, "R8 retire");
      step(6'h3C, 8'h00, 0, 1, "R8 fourth retire");
      step(6'h3C, 8'h00, 0, 0, "R8 closed");

      for (int i = 0; i < 3000; i++) begin
         int unsigned pick = $urandom_range(0, 9);
         logic [5:0] a;
         logic [7:0] d = 8'($urandom);
         case (pick)
            0, 1:    begin a = 6'h3C; if ($urandom_range(0, 1) == 0) d = 8'hD8; end
            2:       a = 6'h37;
            3, 4:    a = 6'h36;
            5:       a = 6'h31;
            default: a = 6'($urandom);
         endcase
         step(a, d, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, "R3 random");
         check("R6 random stub", stub_ps, exp_ps);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule